// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on a CPU I/O-port bus and turns accesses to a two-port configuration mechanism into single-cycle transactions on a configuration bus. Software first writes a 32-bit configuration address to the address port (0xCF8). That address holds an enable flag, a bus/device/function selector and a dword register offset. Software then reads or writes the four-byte data window at 0xCFC to 0xCFF. The block works out the byte lane from the low port bits and the access size. It shifts write data and builds a bit mask for that lane, and it shifts read data back down to bit 0.

When the enable flag is clear, or when no function answers the selector, a read returns all ones, a write changes nothing, and the response carries a no-device flag. Ports that are neither the address port nor the data window are not claimed. The response flags them as a miss so that another decoder can serve them.

Control is a three-state machine:
- **IDLE** waits for a request.
- **CFG** drives the configuration strobe for exactly one cycle and samples the device-present input in that cycle.
- **RESP** presents the result for one cycle.

Transitions:
- **IDLE→RESP** for address-port accesses, unclaimed ports and data accesses with the enable flag clear.
- **IDLE→CFG** for data accesses with the enable flag set.
- **CFG→RESP** always.
- **RESP→IDLE** always.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the latched configuration address is zero, so a read of port 0xCF8 returns 0. No configuration strobe and no response are active until a request arrives.
- R2: A write to port 0xCF8 stores all 32 bits of `io_wdata`, whatever the size. A read of 0xCF8 returns the stored value with bits 30:24 and 1:0 cleared, which is the stored value ANDed with 0x80FFFFFC.
- R3: A data-window write with the enable flag set drives `cfg_wdata` = `io_wdata` shifted left by 8×lane, where lane = `io_port[1:0]`. It drives `cfg_wmask` = a run of 8×bytes ones shifted left by 8×lane, truncated to 32 bits. The size is coded in `io_size`: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R4: During a configuration strobe, `cfg_bdf` equals address bits 23:8 and `cfg_reg` equals address bits 7:2.
- R5: With address bit 31 clear, a data-window access raises no strobe. It returns 0xFFFFFFFF with `io_nodev`=1 and completes one cycle after the request.
- R6: With bit 31 set and `cfg_present` low in the strobe cycle, the response carries `io_nodev`=1. A read then returns 0xFFFFFFFF.
- R7: With bit 31 set and `cfg_present` high, a read returns `cfg_rdata` shifted right by 8×lane, and `io_nodev`=0.
- R8: An access to any other port, including 0xCF9 to 0xCFB, gives `io_miss`=1, `io_nodev`=0 and `io_rdata`=0. It raises no strobe and leaves the latched address unchanged.
- R9: `io_done` is a one-cycle pulse. It comes one cycle after an address-port or unclaimed request, and two cycles after an enabled data request. `cfg_rd`/`cfg_wr` are mutually exclusive one-cycle pulses, each followed immediately by `io_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Request strobe, one cycle, only while idle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | Port number |
| io_size | input | 2 | Access size code (0:1, 1:2, 2/3:4 bytes) |
| io_wdata | input | 32 | Write data, lane 0 aligned |
| io_rdata | output | 32 | Read data, valid with io_done |
| io_done | output | 1 | Response pulse |
| io_miss | output | 1 | Port not claimed, valid with io_done |
| io_nodev | output | 1 | No function answered, valid with io_done |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_bdf | output | 16 | Bus/device/function selector |
| cfg_reg | output | 6 | Dword register offset |
| cfg_wdata | output | 32 | Lane-shifted write data |
| cfg_wmask | output | 32 | Bit mask of written bits |
| cfg_rdata | input | 32 | Read data from the selected function |
| cfg_present | input | 1 | Selected function exists, sampled with the strobe |

## Verification
The checker watches the pulse shapes and ordering of R9 on every cycle. It also checks that a no-device response always carries all ones (R6), that a miss never reports no-device (R8), and that every write mask is a non-empty multiple of whole bytes (R3). The lane arithmetic, the readback masking, the field extraction and the handling of the enable flag depend on the values the bench chooses. Only the bench's sweep can show them: it covers every lane and size against present, absent and disabled functions.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CFG  = 2'd1,
        ST_RESP = 2'd2
    } cfgb_state_t;

    typedef enum logic [1:0] {
        PC_OTHER = 2'd0,
        PC_ADDR  = 2'd1,
        PC_DATA  = 2'd2
    } port_cls_t;

    // size code to byte count: 0->1, 1->2, 2/3->4
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
    import cfgb_pkg::*;
#(
    parameter int          PORT_W    = 16,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_BASE = 16'h0CFC
) (
    input  logic [PORT_W-1:0] port,
    output port_cls_t         cls,
    output logic [1:0]        lane
);
    localparam logic [PORT_W-1:0] ADDR_P = PORT_W'(ADDR_PORT);
    localparam logic [PORT_W-3:0] DATA_W = DATA_BASE[PORT_W-1:2];

    always_comb begin
        lane = port[1:0];
        if (port == ADDR_P)
            cls = PC_ADDR;
        else if (port[PORT_W-1:2] == DATA_W)
            cls = PC_DATA;
        else
            cls = PC_OTHER;
    end
endmodule

// File: rtl/cfgb_lane.sv
module cfgb_lane
    import cfgb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        lane,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] wmask_out,
    output logic [DATA_W-1:0] rdata_out
);
    localparam int SH_W = $clog2(DATA_W) + 1;
    localparam logic [DATA_W-1:0] ONES = '1;

    logic [SH_W-1:0] shamt;
    logic [SH_W-1:0] drop;
    logic [2:0]      nbytes;

    always_comb begin
        nbytes    = size_bytes(size);
        shamt     = SH_W'({lane, 3'b000});
        drop      = SH_W'(DATA_W) - SH_W'({nbytes, 3'b000});
        wdata_out = wdata_in << shamt;
        wmask_out = (ONES >> drop) << shamt;
        rdata_out = rdata_in >> shamt;
    end
endmodule

// File: rtl/cfgb_fsm.sv
module cfgb_fsm
    import cfgb_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter logic [31:0] RB_MASK = 32'h80FF_FFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  port_cls_t         cls,
    input  logic [1:0]        lane,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata_shifted,
    input  logic              present,
    output logic [DATA_W-1:0] addr_q,
    output logic [1:0]        op_lane,
    output logic [1:0]        op_size,
    output logic [DATA_W-1:0] op_wdata,
    output logic              strobe_rd,
    output logic              strobe_wr,
    output logic              done,
    output logic              miss,
    output logic              nodev,
    output logic [DATA_W-1:0] resp_data
);
    localparam logic [DATA_W-1:0] ALL1 = '1;
    localparam int                EN_BIT = DATA_W - 1;

    cfgb_state_t state, state_nx;
    logic        op_wr;
    logic        miss_q, nodev_q;
    logic [DATA_W-1:0] rdata_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) begin
                if (cls == PC_DATA && addr_q[EN_BIT]) state_nx = ST_CFG;
                else                                   state_nx = ST_RESP;
            end
            ST_CFG:  state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            op_wr    <= 1'b0;
            op_lane  <= '0;
            op_size  <= '0;
            op_wdata <= '0;
            miss_q   <= 1'b0;
            nodev_q  <= 1'b0;
            rdata_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    op_wr    <= wr;
                    op_lane  <= lane;
                    op_size  <= size;
                    op_wdata <= wdata;
                    miss_q   <= 1'b0;
                    nodev_q  <= 1'b0;
                    rdata_q  <= '0;
                    unique case (cls)
                        PC_ADDR: begin
                            if (wr) addr_q  <= wdata;
                            else    rdata_q <= addr_q & DATA_W'(RB_MASK);
                        end
                        PC_DATA: begin
                            if (!addr_q[EN_BIT]) begin
                                nodev_q <= 1'b1;
                                rdata_q <= ALL1;
                            end
                        end
                        default: miss_q <= 1'b1;
                    endcase
                end
                ST_CFG: begin
                    nodev_q <= !present;
                    if (!present)   rdata_q <= ALL1;
                    else if (!op_wr) rdata_q <= rdata_shifted;
                    else            rdata_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        strobe_rd = 1'b0;
        strobe_wr = 1'b0;
        done      = 1'b0;
        miss      = 1'b0;
        nodev     = 1'b0;
        resp_data = '0;
        unique case (state)
            ST_CFG: begin
                strobe_rd = !op_wr;
                strobe_wr = op_wr;
            end
            ST_RESP: begin
                done      = 1'b1;
                miss      = miss_q;
                nodev     = nodev_q;
                resp_data = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgb_pkg::*;
#(
    parameter int          PORT_W    = 16,
    parameter int          DATA_W    = 32,
    parameter int          BDF_W     = 16,
    parameter int          REG_W     = 6,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_BASE = 16'h0CFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_done,
    output logic              io_miss,
    output logic              io_nodev,
    output logic              cfg_rd,
    output logic              cfg_wr,
    output logic [BDF_W-1:0]  cfg_bdf,
    output logic [REG_W-1:0]  cfg_reg,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_wmask,
    input  logic [DATA_W-1:0] cfg_rdata,
    input  logic              cfg_present
);
    localparam int REG_LO = 2;
    localparam int BDF_LO = REG_LO + REG_W;

    port_cls_t         cls;
    logic [1:0]        lane, op_lane, op_size;
    logic [DATA_W-1:0] addr_q, op_wdata, rd_sh;

    cfgb_decode #(
        .PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_BASE(DATA_BASE)
    ) u_decode (
        .port(io_port), .cls(cls), .lane(lane)
    );

    cfgb_lane #(.DATA_W(DATA_W)) u_lane (
        .lane(op_lane), .size(op_size),
        .wdata_in(op_wdata), .rdata_in(cfg_rdata),
        .wdata_out(cfg_wdata), .wmask_out(cfg_wmask), .rdata_out(rd_sh)
    );

    cfgb_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(io_req), .wr(io_wr), .cls(cls), .lane(lane), .size(io_size),
        .wdata(io_wdata), .rdata_shifted(rd_sh), .present(cfg_present),
        .addr_q(addr_q), .op_lane(op_lane), .op_size(op_size), .op_wdata(op_wdata),
        .strobe_rd(cfg_rd), .strobe_wr(cfg_wr),
        .done(io_done), .miss(io_miss), .nodev(io_nodev), .resp_data(io_rdata)
    );

    assign cfg_bdf = addr_q[BDF_LO +: BDF_W];
    assign cfg_reg = addr_q[REG_LO +: REG_W];
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_done,
    input logic              io_miss,
    input logic              io_nodev,
    input logic [DATA_W-1:0] io_rdata,
    input logic              cfg_rd,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_wmask
);
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_rd && cfg_wr));

    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd || cfg_wr) |=> !(cfg_rd || cfg_wr));

    assert_strobe_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd || cfg_wr) |=> io_done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> !io_done);

    assert_nodev_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_done && io_nodev) |-> (io_rdata == '1));

    assert_miss_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_done && io_miss) |-> (!io_nodev && io_rdata == '0));

    assert_mask_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> ($countones(cfg_wmask) % 8 == 0 && cfg_wmask != '0));
endmodule

bind cfg_port_bridge cfgb_checker #(.DATA_W(DATA_W)) u_cfgb_checker (
    .clk(clk), .rst_n(rst_n), .io_done(io_done), .io_miss(io_miss),
    .io_nodev(io_nodev), .io_rdata(io_rdata), .cfg_rd(cfg_rd),
    .cfg_wr(cfg_wr), .cfg_wmask(cfg_wmask)
);

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_wr = 1'b0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_done, io_miss, io_nodev, cfg_rd, cfg_wr;
    logic [15:0] cfg_bdf;
    logic [5:0]  cfg_reg;
    logic [31:0] cfg_wdata, cfg_wmask, cfg_rdata;
    logic        cfg_present;

    always #2 clk = ~clk;

    // device model
    assign cfg_present = (cfg_bdf == 16'h0100) || (cfg_bdf == 16'h2A08);
    assign cfg_rdata   = {cfg_bdf, 2'b00, cfg_reg, 8'hC3};

    cfg_port_bridge i_cfg_port_bridge (.*);

    int vectors = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [31:0] cap_wdata, cap_wmask;
    logic [15:0] cap_bdf;
    logic [5:0]  cap_reg;

    always @(posedge clk) begin
        if (cfg_wr) begin
            wr_cnt    <= wr_cnt + 1;
            cap_wdata <= cfg_wdata;
            cap_wmask <= cfg_wmask;
            cap_bdf   <= cfg_bdf;
            cap_reg   <= cfg_reg;
        end
        if (cfg_rd) begin
            rd_cnt  <= rd_cnt + 1;
            cap_bdf <= cfg_bdf;
            cap_reg <= cfg_reg;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [31:0] r_data;
    logic        r_miss, r_nodev;
    int          r_lat;

    task automatic io(input logic wr, input logic [15:0] port, input logic [1:0] sz,
                      input logic [31:0] wd);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_port = port; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        r_lat = 1;
        while (!io_done && r_lat < 8) begin
            @(negedge clk);
            r_lat++;
        end
        r_data = io_rdata; r_miss = io_miss; r_nodev = io_nodev;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [15:0] bdfs [3];
        logic [5:0]  regs [2];
        bdfs[0] = 16'h0100; bdfs[1] = 16'h2A08; bdfs[2] = 16'h0300;
        regs[0] = 6'h00;    regs[1] = 6'h3F;

        repeat (3) @(negedge clk);
        // R1: nothing active during / right after reset
        check("R1 done in reset", {31'b0, io_done}, 32'h0);
        check("R1 strobe in reset", {30'b0, cfg_rd, cfg_wr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {29'b0, io_done, cfg_rd, cfg_wr}, 32'h0);
        io(1'b0, 16'h0CF8, 2'd2, 32'h0);
        check("R1 address reset value", r_data, 32'h0);
        check("R9 address latency", r_lat, 1);

        for (int en = 0; en < 2; en++) begin
            for (int b = 0; b < 3; b++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [31:0] a;
                    logic        pres;
                    a = {en[0], 7'h55, bdfs[b], regs[g], 2'b11};
                    pres = (b != 2);
                    io(1'b1, 16'h0CF8, 2'd0, a);   // R2: full 32 bits regardless of size
                    check("R2 addr write miss flag", {31'b0, r_miss}, 32'h0);
                    io(1'b0, 16'h0CF8, 2'd2, 32'h0);
                    check("R2 address readback mask", r_data, a & 32'h80FF_FFFC);
                    for (int ln = 0; ln < 4; ln++) begin
                        for (int sz = 0; sz < 3; sz++) begin
                            int          w0, r0, nb;
                            logic [31:0] wd, exp_mask, exp_rd;
                            nb = 1 << sz;
                            wd = 32'hA5000000 ^ (ln * 32'h01010101) ^ (sz << 4) ^ (b << 9);
                            exp_mask = (32'hFFFF_FFFF >> (32 - 8 * nb)) << (8 * ln);
                            exp_rd = {bdfs[b], 2'b00, regs[g], 8'hC3} >> (8 * ln);
                            w0 = wr_cnt; r0 = rd_cnt;
                            io(1'b1, 16'h0CFC + 16'(ln), 2'(sz), wd);
                            if (en == 0) begin
                                check("R5 write no strobe", 32'(wr_cnt - w0), 0);
                                check("R5 write nodev", {31'b0, r_nodev}, 32'h1);
                                check("R5 latency", r_lat, 1);
                            end else begin
                                check("R9 write strobe count", 32'(wr_cnt - w0), 1);
                                check("R9 data latency", r_lat, 2);
                                check("R3 wdata shift", cap_wdata, wd << (8 * ln));
                                check("R3 wmask", cap_wmask, exp_mask);
                                check("R4 bdf", {16'h0, cap_bdf}, {16'h0, bdfs[b]});
                                check("R4 reg", {26'h0, cap_reg}, {26'h0, regs[g]});
                                check("R6 write nodev", {31'b0, r_nodev}, {31'b0, !pres});
                            end
                            io(1'b0, 16'h0CFC + 16'(ln), 2'(sz), 32'h0);
                            if (en == 0) begin
                                check("R5 read no strobe", 32'(rd_cnt - r0), 0);
                                check("R5 read all ones", r_data, 32'hFFFF_FFFF);
                            end else if (!pres) begin
                                check("R6 read all ones", r_data, 32'hFFFF_FFFF);
                                check("R6 read nodev", {31'b0, r_nodev}, 32'h1);
                            end else begin
                                check("R7 read shift", r_data, exp_rd);
                                check("R7 read nodev", {31'b0, r_nodev}, 32'h0);
                                check("R4 read reg", {26'h0, cap_reg}, {26'h0, regs[g]});
                            end
                        end
                    end
                end
            end
        end

        // R8: unclaimed ports
        begin
            logic [15:0] others [4];
            logic [31:0] keep;
            keep = 32'h8001_0004;
            others[0] = 16'h0CF9; others[1] = 16'h0CFB;
            others[2] = 16'h0080; others[3] = 16'h1CF8;
            io(1'b1, 16'h0CF8, 2'd2, keep);
            for (int k = 0; k < 4; k++) begin
                int w0, r0;
                w0 = wr_cnt; r0 = rd_cnt;
                io(1'b1, others[k], 2'd2, 32'hDEAD_BEEF);
                check("R8 write miss", {31'b0, r_miss}, 32'h1);
                check("R8 write nodev", {31'b0, r_nodev}, 32'h0);
                io(1'b0, others[k], 2'd0, 32'h0);
                check("R8 read miss", {31'b0, r_miss}, 32'h1);
                check("R8 read data", r_data, 32'h0);
                check("R8 latency", r_lat, 1);
                check("R8 no strobes", 32'((wr_cnt - w0) + (rd_cnt - r0)), 0);
                io(1'b0, 16'h0CF8, 2'd2, 32'h0);
                check("R8 address untouched", r_data, keep & 32'h80FF_FFFC);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule